// File: doc/BRIEF.md
# Internal Data Memory Access Unit

This block serves every operand access that an 8-bit microcontroller core makes into its 256-byte on-chip scratch RAM and its special-function-register (SFR) window. The core presents one request: an addressing mode, an 8-bit address or register number, the two bank-select bits, and the write data and write strobe. The unit turns this into a physical RAM address or an SFR bus cycle. It returns the read byte, or the read bit in bit mode. It also keeps the 8-bit stack pointer and performs pushes and pops.

The same 8-bit address resolves differently depending on the mode. Register mode folds the register number into the selected bank. Direct mode reaches RAM below 80h and the SFR bus from 80h up. Indirect mode reaches all 256 RAM bytes and never the SFR bus. Bit mode folds a bit address into a byte and a bit index. A bit write is a read-modify-write of the byte that holds it, so only the addressed bit changes. When no SFR answers, the read data is 00h and a miss flag is raised.

A small state machine sequences each request. ST_IDLE waits for `req` and captures the request, then goes to ST_ACCESS. ST_ACCESS performs the access. It returns to ST_IDLE, or, for a bit write, moves to ST_MERGE. ST_MERGE writes the merged byte back and returns to ST_IDLE. `done` is high for exactly one cycle, in the final state of each request. The caller waits for `done` before it raises `req` again. Mode codes 5 to 7 are decoded as direct mode.

Top module: `iram_access_unit`

## Requirements
- R1: Register mode (mode code 0) maps register number addr[2:0] to RAM byte {bank[1:0], addr[2:0]}.
- R2: Direct mode (code 1) with addr below 80h and indirect mode (code 2) with addr below 80h reach the same RAM byte, addr.
- R3: Indirect mode (code 2) with addr 80h to FFh reaches upper RAM and never raises `sfr_req`.
- R4: Direct mode (code 1) with addr 80h to FFh raises `sfr_req` with `sfr_addr` equal to addr and leaves RAM unchanged.
- R5: An SFR access that gets no `sfr_ack` returns rdata 00h and raises `sfr_miss` with `done`.
- R6: Bit mode (code 4) with bit address below 80h selects RAM byte 20h + addr[6:3] and bit addr[2:0]; `rbit` returns that bit.
- R7: Bit mode (code 4) with bit address 80h or above selects SFR byte {addr[7:3], 000} and bit addr[2:0].
- R8: A bit write (code 4, wr=1) changes only the selected bit of the containing byte, writing `wbit` there, and completes two cycles after the request.
- R9: Stack mode (code 3) with wr=1 increments the stack pointer and then writes wdata at the new value. With wr=0 it returns the byte at the stack pointer and then decrements it.
- R10: The stack pointer is 07h after reset, and `done` and `sfr_req` are low.
- R11: A request other than a bit write asserts `done` for one cycle, one cycle after `req` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Request strobe, sampled in ST_IDLE |
| wr | input | 1 | 1 = write (push in stack mode), 0 = read (pop) |
| mode | input | 3 | Addressing mode: 0 reg, 1 direct, 2 indirect, 3 stack, 4 bit |
| addr | input | 8 | Address, register number or bit address |
| bank | input | 2 | Register bank select |
| wdata | input | 8 | Byte write data |
| wbit | input | 1 | Bit write data |
| done | output | 1 | Request complete, one-cycle pulse |
| rdata | output | 8 | Read byte, valid with done |
| rbit | output | 1 | Selected bit, valid with done in bit mode |
| sp | output | 8 | Current stack pointer |
| sfr_req | output | 1 | SFR bus cycle request |
| sfr_wr | output | 1 | SFR bus write |
| sfr_addr | output | 8 | SFR byte address |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data |
| sfr_ack | input | 1 | An SFR answered the current cycle |
| sfr_miss | output | 1 | No SFR answered, valid with done |

## Verification
The checker watches on every cycle that indirect accesses never reach the SFR bus and that high direct addresses always do. It also checks that push and pop move the stack pointer by exactly one, that a bit write-back alters at most one bit, and that `done` is a single-cycle pulse that never appears in ST_IDLE. The bench scenarios cover the rest: the bank-to-address mapping, the bit-address folding for both RAM and SFR, the 00h/miss response, the reset value of the stack pointer, and the data that comes back after writes through one mode and reads through another.

// File: rtl/iram_pkg.sv
package iram_pkg;
    localparam int BYTE_W    = 8;
    localparam int BIT_IDX_W = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        MODE_REG = 3'd0,
        MODE_DIR = 3'd1,
        MODE_IND = 3'd2,
        MODE_STK = 3'd3,
        MODE_BIT = 3'd4
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_MERGE  = 2'd2
    } state_e;
endpackage

// File: rtl/iram_addr_steer.sv
module iram_addr_steer
    import iram_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int BANK_W   = 2,
    parameter int NREGS    = 8,
    parameter logic [ADDR_W-1:0] BIT_BASE = 8'h20
) (
    input  logic [2:0]        mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BANK_W-1:0] bank,
    input  logic              push,
    input  logic [ADDR_W-1:0] sp,
    output logic [ADDR_W-1:0] phys,
    output logic              to_sfr,
    output logic [BIT_IDX_W-1:0] bit_idx
);
    localparam int REG_W = $clog2(NREGS);
    localparam int ROW_W = ADDR_W - 1 - BIT_IDX_W;

    logic [ADDR_W-1:0] reg_byte;
    logic [ADDR_W-1:0] bit_ram_byte;
    logic [ADDR_W-1:0] bit_sfr_byte;

    assign reg_byte     = ADDR_W'({bank, addr[REG_W-1:0]});
    assign bit_ram_byte = BIT_BASE + ADDR_W'(addr[ADDR_W-2:BIT_IDX_W]);
    assign bit_sfr_byte = {addr[ADDR_W-1:BIT_IDX_W], {BIT_IDX_W{1'b0}}};

    always_comb begin
        phys    = addr;
        to_sfr  = 1'b0;
        bit_idx = addr[BIT_IDX_W-1:0];
        unique case (mode)
            MODE_REG: phys = reg_byte;
            MODE_IND: phys = addr;
            MODE_STK: phys = push ? sp + 1'b1 : sp;
            MODE_BIT: begin
                phys   = addr[ADDR_W-1] ? bit_sfr_byte : bit_ram_byte;
                to_sfr = addr[ADDR_W-1];
            end
            default: begin
                phys   = addr;
                to_sfr = addr[ADDR_W-1];
            end
        endcase
    end

    logic [ROW_W-1:0] unused_row;
    assign unused_row = addr[ADDR_W-2:BIT_IDX_W];
endmodule

// File: rtl/iram_array.sv
module iram_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/iram_bit_merge.sv
module iram_bit_merge
    import iram_pkg::*;
(
    input  logic [BYTE_W-1:0]    byte_in,
    input  logic [BIT_IDX_W-1:0] idx,
    input  logic                 bit_val,
    output logic [BYTE_W-1:0]    byte_out,
    output logic                 bit_out
);
    always_comb begin
        byte_out      = byte_in;
        byte_out[idx] = bit_val;
    end
    assign bit_out = byte_in[idx];
endmodule

// File: rtl/iram_access_unit.sv
module iram_access_unit
    import iram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BANK_W = 2,
    parameter int NREGS  = 8,
    parameter logic [ADDR_W-1:0] BIT_BASE = 8'h20,
    parameter logic [ADDR_W-1:0] SP_RESET = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr,
    input  logic [2:0]        mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BANK_W-1:0] bank,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              wbit,
    output logic              done,
    output logic [BYTE_W-1:0] rdata,
    output logic              rbit,
    output logic [ADDR_W-1:0] sp,
    output logic              sfr_req,
    output logic              sfr_wr,
    output logic [ADDR_W-1:0] sfr_addr,
    output logic [BYTE_W-1:0] sfr_wdata,
    input  logic [BYTE_W-1:0] sfr_rdata,
    input  logic              sfr_ack,
    output logic              sfr_miss
);
    state_e state, state_nx;

    logic [2:0]        cap_mode;
    logic [ADDR_W-1:0] cap_addr;
    logic [BANK_W-1:0] cap_bank;
    logic              cap_wr;
    logic [BYTE_W-1:0] cap_wdata;
    logic              cap_wbit;
    logic [BYTE_W-1:0] hold_byte;
    logic              hold_miss;

    logic [ADDR_W-1:0] phys;
    logic              to_sfr;
    logic [BIT_IDX_W-1:0] bit_idx;
    logic              is_push, is_stack, bit_write;

    logic              ram_we;
    logic [ADDR_W-1:0] ram_waddr;
    logic [BYTE_W-1:0] ram_wdata;
    logic [BYTE_W-1:0] ram_rd;

    logic [BYTE_W-1:0] live_byte, merge_src, merged;
    logic              sel_bit;

    assign is_stack  = (cap_mode == MODE_STK);
    assign is_push   = is_stack && cap_wr;
    assign bit_write = (cap_mode == MODE_BIT) && cap_wr;

    iram_addr_steer #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .NREGS(NREGS), .BIT_BASE(BIT_BASE)
    ) u_steer (
        .mode(cap_mode), .addr(cap_addr), .bank(cap_bank), .push(is_push),
        .sp(sp), .phys(phys), .to_sfr(to_sfr), .bit_idx(bit_idx)
    );

    iram_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_ram (
        .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
        .raddr(phys), .rdata(ram_rd)
    );

    assign live_byte = to_sfr ? (sfr_ack ? sfr_rdata : '0) : ram_rd;
    assign merge_src = (state == ST_MERGE) ? hold_byte : live_byte;

    iram_bit_merge u_merge (
        .byte_in(merge_src), .idx(bit_idx), .bit_val(cap_wbit),
        .byte_out(merged), .bit_out(sel_bit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   state_nx = req ? ST_ACCESS : ST_IDLE;
            ST_ACCESS: state_nx = bit_write ? ST_MERGE : ST_IDLE;
            ST_MERGE:  state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Request capture, hold byte and stack pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_mode  <= MODE_REG;
            cap_addr  <= '0;
            cap_bank  <= '0;
            cap_wr    <= 1'b0;
            cap_wdata <= '0;
            cap_wbit  <= 1'b0;
            hold_byte <= '0;
            hold_miss <= 1'b0;
            sp        <= SP_RESET;
        end else begin
            if (state == ST_IDLE && req) begin
                cap_mode  <= mode;
                cap_addr  <= addr;
                cap_bank  <= bank;
                cap_wr    <= wr;
                cap_wdata <= wdata;
                cap_wbit  <= wbit;
            end
            if (state == ST_ACCESS) begin
                hold_byte <= live_byte;
                hold_miss <= to_sfr && !sfr_ack;
                if (is_stack) sp <= cap_wr ? sp + 1'b1 : sp - 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        done      = 1'b0;
        rdata     = '0;
        rbit      = 1'b0;
        sfr_req   = 1'b0;
        sfr_wr    = 1'b0;
        sfr_addr  = phys;
        sfr_wdata = cap_wdata;
        sfr_miss  = 1'b0;
        ram_we    = 1'b0;
        ram_waddr = phys;
        ram_wdata = cap_wdata;
        unique case (state)
            ST_IDLE: ;
            ST_ACCESS: begin
                done  = !bit_write;
                rdata = live_byte;
                rbit  = sel_bit;
                if (to_sfr) begin
                    sfr_req  = 1'b1;
                    sfr_wr   = cap_wr && !bit_write;
                    sfr_miss = !sfr_ack;
                end else begin
                    ram_we   = cap_wr && !bit_write;
                end
            end
            ST_MERGE: begin
                done     = 1'b1;
                rdata    = merged;
                rbit     = cap_wbit;
                sfr_miss = hold_miss;
                if (to_sfr) begin
                    sfr_req   = 1'b1;
                    sfr_wr    = 1'b1;
                    sfr_wdata = merged;
                end else begin
                    ram_we    = 1'b1;
                    ram_wdata = merged;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/iram_access_checker.sv
module iram_access_checker
    import iram_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input state_e     state,
    input logic [2:0] cap_mode,
    input logic [7:0] cap_addr,
    input logic       cap_wr,
    input logic [7:0] sp,
    input logic       done,
    input logic       sfr_req,
    input logic       ram_we,
    input logic [7:0] ram_wdata,
    input logic [7:0] hold_byte
);
    // R3: indirect accesses never reach the SFR bus
    p_indirect_no_sfr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && cap_mode == MODE_IND) |-> !sfr_req);

    // R4: direct access at 80h and above goes to the SFR bus, not RAM
    p_direct_high_sfr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACCESS && cap_mode == MODE_DIR && cap_addr[7]) |-> (sfr_req && !ram_we));

    // R9: push raises the stack pointer by one
    p_push_inc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACCESS && cap_mode == MODE_STK && cap_wr) |=> (sp == $past(sp) + 8'd1));

    // R9: pop lowers the stack pointer by one
    p_pop_dec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACCESS && cap_mode == MODE_STK && !cap_wr) |=> (sp == $past(sp) - 8'd1));

    // R8: a RAM write-back of a bit write changes at most one bit
    p_one_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MERGE && ram_we) |-> ($countones(ram_wdata ^ hold_byte) <= 1));

    // R11: done is a single-cycle pulse
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: nothing is signalled while idle
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!done && !sfr_req));
endmodule

bind iram_access_unit iram_access_checker u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .cap_mode(cap_mode),
    .cap_addr(cap_addr), .cap_wr(cap_wr), .sp(sp), .done(done),
    .sfr_req(sfr_req), .ram_we(ram_we), .ram_wdata(ram_wdata),
    .hold_byte(hold_byte)
);

// File: tb/iram_access_unit_test.sv
module iram_access_unit_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0, wr = 1'b0, wbit = 1'b0;
    logic [2:0] mode = 3'd0;
    logic [7:0] addr = 8'h00, wdata = 8'h00;
    logic [1:0] bank = 2'd0;
    logic       done, rbit, sfr_req, sfr_wr, sfr_miss, sfr_ack;
    logic [7:0] rdata, sp, sfr_addr, sfr_wdata, sfr_rdata;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iram_access_unit uut (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .mode(mode), .addr(addr),
        .bank(bank), .wdata(wdata), .wbit(wbit), .done(done), .rdata(rdata),
        .rbit(rbit), .sp(sp), .sfr_req(sfr_req), .sfr_wr(sfr_wr),
        .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
        .sfr_ack(sfr_ack), .sfr_miss(sfr_miss)
    );

    // SFR model: 16 registers answer at 80h..8Fh
    logic [7:0] sfr_regs [16];
    assign sfr_ack   = sfr_req && (sfr_addr[7:4] == 4'h8);
    assign sfr_rdata = sfr_regs[sfr_addr[3:0]];
    always_ff @(posedge clk) begin
        if (sfr_req && sfr_wr && sfr_ack) sfr_regs[sfr_addr[3:0]] <= sfr_wdata;
    end

    logic [7:0] r_data;
    logic       r_bit, r_miss, r_sfr_seen;
    int         r_lat;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic op(input logic [2:0] m, input logic [7:0] a, input logic [1:0] b,
                      input logic w, input logic [7:0] d, input logic wb);
        @(negedge clk);
        mode = m; addr = a; bank = b; wr = w; wdata = d; wbit = wb; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        r_lat = 1;
        r_sfr_seen = sfr_req;
        while (!done && r_lat < 8) begin
            @(negedge clk);
            r_lat++;
            r_sfr_seen = r_sfr_seen | sfr_req;
        end
        r_data = rdata; r_bit = rbit; r_miss = sfr_miss;
        @(negedge clk);
    endtask

    // {chk, mode, addr, bank, wr, wbit, wdata, expected rdata}
    localparam int NV = 13;
    localparam logic [31:0] VEC [NV] = '{
        {1'b0, 3'd0, 8'h05, 2'd2, 1'b1, 1'b0, 8'hA5, 8'h00},
        {1'b1, 3'd1, 8'h15, 2'd0, 1'b0, 1'b0, 8'h00, 8'hA5},
        {1'b0, 3'd1, 8'h30, 2'd0, 1'b1, 1'b0, 8'h3C, 8'h00},
        {1'b1, 3'd2, 8'h30, 2'd0, 1'b0, 1'b0, 8'h00, 8'h3C},
        {1'b0, 3'd2, 8'hC4, 2'd0, 1'b1, 1'b0, 8'h77, 8'h00},
        {1'b1, 3'd2, 8'hC4, 2'd0, 1'b0, 1'b0, 8'h00, 8'h77},
        {1'b0, 3'd0, 8'h03, 2'd0, 1'b1, 1'b0, 8'h11, 8'h00},
        {1'b1, 3'd1, 8'h03, 2'd0, 1'b0, 1'b0, 8'h00, 8'h11},
        {1'b0, 3'd1, 8'h22, 2'd0, 1'b1, 1'b0, 8'h00, 8'h00},
        {1'b0, 3'd4, 8'h15, 2'd0, 1'b1, 1'b1, 8'h00, 8'h00},
        {1'b1, 3'd1, 8'h22, 2'd0, 1'b0, 1'b0, 8'h00, 8'h20},
        {1'b0, 3'd0, 8'h07, 2'd3, 1'b1, 1'b0, 8'h5A, 8'h00},
        {1'b1, 3'd1, 8'h1F, 2'd0, 1'b0, 1'b0, 8'h00, 8'h5A}
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) sfr_regs[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(sp == 8'h07, "R10 sp reset", sp, 8'h07);
        check(!done && !sfr_req, "R10 idle outputs", {done, sfr_req}, 0);
        rst_n = 1'b1;

        // Vector table: R1 banks, R2 direct/indirect, R3 upper RAM, R8 bit write
        for (int i = 0; i < NV; i++) begin
            op(VEC[i][30:28], VEC[i][27:20], VEC[i][19:18], VEC[i][17],
               VEC[i][15:8], VEC[i][16]);
            if (VEC[i][31])
                check(r_data == VEC[i][7:0], $sformatf("R1/R2/R3/R8 vector %0d", i),
                      r_data, VEC[i][7:0]);
        end

        // R11: plain read latency
        op(3'd1, 8'h30, 2'd0, 1'b0, 8'h00, 1'b0);
        check(r_lat == 1, "R11 read latency", r_lat, 1);

        // R4: direct high write reaches SFR, reads back via SFR
        op(3'd1, 8'h83, 2'd0, 1'b1, 8'h5C, 1'b0);
        check(r_sfr_seen, "R4 sfr request", r_sfr_seen, 1);
        // R3: indirect at the same address goes to RAM
        op(3'd2, 8'h83, 2'd0, 1'b1, 8'hE1, 1'b0);
        check(!r_sfr_seen, "R3 no sfr on indirect write", r_sfr_seen, 0);
        op(3'd2, 8'h83, 2'd0, 1'b0, 8'h00, 1'b0);
        check(r_data == 8'hE1 && !r_sfr_seen, "R3 indirect upper read", r_data, 8'hE1);
        op(3'd1, 8'h83, 2'd0, 1'b0, 8'h00, 1'b0);
        check(r_data == 8'h5C, "R4 sfr readback", r_data, 8'h5C);
        check(sfr_regs[3] == 8'h5C, "R4 sfr model holds value", sfr_regs[3], 8'h5C);

        // R5: unanswered SFR
        op(3'd1, 8'h9A, 2'd0, 1'b0, 8'h00, 1'b0);
        check(r_data == 8'h00, "R5 miss data", r_data, 0);
        check(r_miss, "R5 miss flag", r_miss, 1);
        op(3'd1, 8'h83, 2'd0, 1'b0, 8'h00, 1'b0);
        check(!r_miss, "R5 no miss when answered", r_miss, 0);

        // R7: SFR bit write/read, bit 8Bh -> byte 88h bit 3
        op(3'd1, 8'h88, 2'd0, 1'b1, 8'h00, 1'b0);
        op(3'd4, 8'h8B, 2'd0, 1'b1, 8'h00, 1'b1);
        check(r_lat == 2, "R8 bit write latency", r_lat, 2);
        op(3'd1, 8'h88, 2'd0, 1'b0, 8'h00, 1'b0);
        check(r_data == 8'h08, "R7 sfr bit byte", r_data, 8'h08);
        op(3'd4, 8'h8B, 2'd0, 1'b0, 8'h00, 1'b0);
        check(r_bit == 1'b1, "R7 sfr bit read set", r_bit, 1);
        op(3'd4, 8'h8C, 2'd0, 1'b0, 8'h00, 1'b0);
        check(r_bit == 1'b0, "R7 sfr bit read clear", r_bit, 0);

        // R6: RAM bit read, bit 7Fh -> byte 2Fh bit 7
        op(3'd1, 8'h2F, 2'd0, 1'b1, 8'h80, 1'b0);
        op(3'd4, 8'h7F, 2'd0, 1'b0, 8'h00, 1'b0);
        check(r_bit == 1'b1, "R6 bit 7F", r_bit, 1);
        op(3'd4, 8'h7E, 2'd0, 1'b0, 8'h00, 1'b0);
        check(r_bit == 1'b0, "R6 bit 7E", r_bit, 0);

        // R8: clear one bit, others kept; bit 2Ah -> byte 25h bit 2
        op(3'd1, 8'h25, 2'd0, 1'b1, 8'hFF, 1'b0);
        op(3'd4, 8'h2A, 2'd0, 1'b1, 8'h00, 1'b0);
        op(3'd1, 8'h25, 2'd0, 1'b0, 8'h00, 1'b0);
        check(r_data == 8'hFB, "R8 rmw clear", r_data, 8'hFB);

        // R9: push then pop
        op(3'd3, 8'h00, 2'd0, 1'b1, 8'hAB, 1'b0);
        check(sp == 8'h08, "R9 push sp", sp, 8'h08);
        op(3'd1, 8'h08, 2'd0, 1'b0, 8'h00, 1'b0);
        check(r_data == 8'hAB, "R9 push data at new sp", r_data, 8'hAB);
        op(3'd3, 8'h00, 2'd0, 1'b1, 8'hCD, 1'b0);
        op(3'd3, 8'h00, 2'd0, 1'b0, 8'h00, 1'b0);
        check(r_data == 8'hCD && sp == 8'h08, "R9 pop data", r_data, 8'hCD);
        op(3'd3, 8'h00, 2'd0, 1'b0, 8'h00, 1'b0);
        check(r_data == 8'hAB && sp == 8'h07, "R9 pop sp", sp, 8'h07);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule